// File: doc/BRIEF.md
# Intersection Traffic Light Sequencer

This block sequences the lamps of a three-signal intersection. Signal head 1 has a protected left-turn arrow. Heads 2 and 3 each carry a "no turn on red" indicator, and the crossing has pedestrian walk lamps. The block runs from a fast system clock. It also takes three inputs:

- a slow 1 Hz square wave that paces every interval;
- a momentary walk push-button;
- a car sensor in the left-turn lane.

Inside, three parts work together. A synchronizer turns each rising edge of the slow wave into a single-cycle tick. An interval timer counts those ticks and restarts whenever the phase changes. A latch remembers a walk request after the button is released.

The phase machine cycles through eight phases. The main green on heads 1 and 3 leads to its yellow, then to the cross green on head 2 and its yellow. At the end of the cross yellow the machine takes one of three routes:

- a pending walk request inserts the walk and clearing phases;
- otherwise, an occupied turn lane starts the protected arrow;
- otherwise, the cycle returns to the main green.

While the arrow is green, the sensor is tested again at the end of every short interval, so the arrow stays green for as long as cars wait. All sixteen lamps are decoded from the phase alone.

Top module: `tl_sequencer`

## Requirements
- R1: A synchronous reset enters the main-green phase, clears the walk latch and the timer. The first main green then lasts the full long interval (15 ticks), and no walk phase follows unless the button is pressed after reset.
- R2: `lamps_o` bit map: 0 h1 red, 1 h1 yellow, 2 h1 green, 3 arrow yellow, 4 arrow green, 5 h2 red, 6 h2 yellow, 7 h2 green, 8 h2 no-turn-on-red, 9 h3 red, 10 h3 yellow, 11 h3 green, 12 h3 no-turn-on-red, 13 don't walk, 14 don't start walking, 15 walk. The lamps lit in each phase are as follows; every other bit is 0.

  | Phase | Lamps lit |
  |---|---|
  | main green | 2, 5, 11, 13 |
  | main yellow | 1, 5, 10, 13 |
  | cross green | 0, 7, 9, 13 |
  | cross yellow | 0, 6, 9, 13 |
  | walk | 0, 5, 9, 15 |
  | don't start walking | 0, 5, 9, 14 |
  | arrow green | 0, 4, 5, 9, 12, 13 |
  | arrow yellow | 0, 3, 5, 9, 12, 13 |

- R3: Main green lasts the long interval (15 ticks), main yellow the short interval (4 ticks), cross green the long interval and cross yellow the short interval.
- R4: At the end of cross yellow the next phase is walk if a request is latched, else arrow green if the sensor is high, else main green.
- R5: A press of any length sets the walk latch, which holds after release. The latch clears when the walk phase is entered, so the following cycle has no walk phase.
- R6: Walk lasts the long interval, don't-start-walking the short interval. It is followed by arrow green if the sensor is high, else by main green.
- R7: In arrow green the sensor is tested at the end of each short interval. If it is high, the arrow stays green for another short interval; if it is low, the next phase is arrow yellow.
- R8: Arrow yellow lasts the short interval and returns to main green.
- R9: The sensor is ignored outside the decision points. A car present only during the main and cross green phases does not start an arrow phase.
- R10: Each rising edge of the slow input produces exactly one tick. The lamps change only in the cycle after a tick, and phase durations count ticks from phase entry.
- R11: Each vehicle head shows exactly one of red, yellow and green, and the walk head shows exactly one of its three lamps. The head-2 no-turn-on-red lamp is never lit, and the head-3 one is lit exactly while an arrow lamp is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | 1 Hz pacing wave, asynchronous to clk |
| walk_btn_i | input | 1 | Walk push-button, high while pressed, synchronous to clk |
| car_sense_i | input | 1 | Turn-lane car sensor, high while occupied |
| lamps_o | output | 16 | Lamp outputs, bit map in R2 |

## Verification
The hardest situation to reach is an extended arrow that ends mid-window. The sensor must stay high across one re-check and drop between two re-checks, so only the second test may see it low.

The stimulus counts slow edges from arrow entry and releases the sensor six edges in. The arrow must therefore last exactly eight ticks.

A second hard case combines a walk request with an occupied lane, so walk must win at cross yellow and the arrow must follow the clearing phase. A reset in mid-phase, with a request pending, shows that the timer and the latch both restart.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [2:0] {
        PH_MAIN_GO,
        PH_MAIN_WARN,
        PH_CROSS_GO,
        PH_CROSS_WARN,
        PH_PED_GO,
        PH_PED_CLEAR,
        PH_ARROW_GO,
        PH_ARROW_WARN
    } phase_e;

    // first field is the most significant bit of lamps_o
    typedef struct packed {
        logic ped_go;
        logic ped_clear;
        logic ped_stop;
        logic h3_nror;
        logic h3_grn;
        logic h3_yel;
        logic h3_red;
        logic h2_nror;
        logic h2_grn;
        logic h2_yel;
        logic h2_red;
        logic arrow_grn;
        logic arrow_yel;
        logic h1_grn;
        logic h1_yel;
        logic h1_red;
    } lamps_t;

    function automatic lamps_t phase_lamps(phase_e p);
        lamps_t l;
        l = '0;
        unique case (p)
            PH_MAIN_GO: begin
                l.h1_grn = 1'b1; l.h3_grn = 1'b1; l.h2_red = 1'b1; l.ped_stop = 1'b1;
            end
            PH_MAIN_WARN: begin
                l.h1_yel = 1'b1; l.h3_yel = 1'b1; l.h2_red = 1'b1; l.ped_stop = 1'b1;
            end
            PH_CROSS_GO: begin
                l.h2_grn = 1'b1; l.h1_red = 1'b1; l.h3_red = 1'b1; l.ped_stop = 1'b1;
            end
            PH_CROSS_WARN: begin
                l.h2_yel = 1'b1; l.h1_red = 1'b1; l.h3_red = 1'b1; l.ped_stop = 1'b1;
            end
            PH_PED_GO: begin
                l.h1_red = 1'b1; l.h2_red = 1'b1; l.h3_red = 1'b1; l.ped_go = 1'b1;
            end
            PH_PED_CLEAR: begin
                l.h1_red = 1'b1; l.h2_red = 1'b1; l.h3_red = 1'b1; l.ped_clear = 1'b1;
            end
            PH_ARROW_GO: begin
                l.arrow_grn = 1'b1; l.h1_red = 1'b1; l.h2_red = 1'b1; l.h3_red = 1'b1;
                l.h3_nror = 1'b1; l.ped_stop = 1'b1;
            end
            PH_ARROW_WARN: begin
                l.arrow_yel = 1'b1; l.h1_red = 1'b1; l.h2_red = 1'b1; l.h3_red = 1'b1;
                l.h3_nror = 1'b1; l.ped_stop = 1'b1;
            end
            default: l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/tl_tick_sync.sv
module tl_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_i,
    output logic tick_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], slow_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    // rising edge seen between the last sync stage and the edge stage
    assign tick_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
    parameter int SHORT_TICKS = 4,
    parameter int LONG_TICKS  = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic restart_i,
    output logic short_done_o,
    output logic long_done_o
);
    localparam int CNT_W = $clog2(LONG_TICKS + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(LONG_TICKS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)                    cnt_d = '0;
        else if (tick_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign short_done_o = tick_i && (cnt_q == SHORT_LAST);
    assign long_done_o  = tick_i && (cnt_q == LONG_LAST);
endmodule

// File: rtl/tl_walk_latch.sv
module tl_walk_latch (
    input  logic clk,
    input  logic rst,
    input  logic press_i,
    input  logic take_i,
    output logic req_o
);
    logic req_d, req_q;

    always_comb begin
        // a press in the consuming cycle stays pending
        req_d = press_i | (req_q & ~take_i);
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_d;
    end

    assign req_o = req_q;
endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
    import tl_pkg::*;
#(
    parameter int SHORT_TICKS = 4,
    parameter int LONG_TICKS  = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_clk_i,
    input  logic        walk_btn_i,
    input  logic        car_sense_i,
    output logic [15:0] lamps_o
);
    typedef struct packed {
        phase_e phase;
    } seq_t;

    seq_t   st_d, st_q;
    phase_e phase_q;
    logic   tick, short_done, long_done, restart, walk_req, walk_take;

    tl_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .slow_i(slow_clk_i), .tick_o(tick)
    );

    tl_interval_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
        .clk(clk), .rst(rst), .tick_i(tick), .restart_i(restart),
        .short_done_o(short_done), .long_done_o(long_done)
    );

    tl_walk_latch u_walk (
        .clk(clk), .rst(rst), .press_i(walk_btn_i), .take_i(walk_take), .req_o(walk_req)
    );

    assign phase_q = st_q.phase;

    always_comb begin
        logic recheck;
        st_d    = st_q;
        recheck = 1'b0;
        unique case (st_q.phase)
            PH_MAIN_GO:    if (long_done)  st_d.phase = PH_MAIN_WARN;
            PH_MAIN_WARN:  if (short_done) st_d.phase = PH_CROSS_GO;
            PH_CROSS_GO:   if (long_done)  st_d.phase = PH_CROSS_WARN;
            PH_CROSS_WARN: if (short_done) begin
                if (walk_req)         st_d.phase = PH_PED_GO;
                else if (car_sense_i) st_d.phase = PH_ARROW_GO;
                else                  st_d.phase = PH_MAIN_GO;
            end
            PH_PED_GO:     if (long_done)  st_d.phase = PH_PED_CLEAR;
            PH_PED_CLEAR:  if (short_done) st_d.phase = car_sense_i ? PH_ARROW_GO : PH_MAIN_GO;
            PH_ARROW_GO:   if (short_done) begin
                if (car_sense_i) recheck = 1'b1;
                else             st_d.phase = PH_ARROW_WARN;
            end
            PH_ARROW_WARN: if (short_done) st_d.phase = PH_MAIN_GO;
            default:       st_d.phase = PH_MAIN_GO;
        endcase
        restart   = recheck || (st_d.phase != st_q.phase);
        walk_take = (st_d.phase == PH_PED_GO) && (st_q.phase != PH_PED_GO);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_MAIN_GO};
        else     st_q <= st_d;
    end

    assign lamps_o = phase_lamps(st_q.phase);
endmodule

// File: rtl/tl_sequencer_chk.sv
module tl_sequencer_chk
    import tl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [15:0] lamps,
    input logic        tick,
    input phase_e      phase,
    input logic        walk_req,
    input logic        take,
    input logic        car,
    input logic        short_done
);
    a_r11_head1_one: assert property (@(posedge clk) disable iff (rst)
        $countones(lamps[2:0]) == 1);
    a_r11_head2_one: assert property (@(posedge clk) disable iff (rst)
        $countones(lamps[7:5]) == 1);
    a_r11_head3_one: assert property (@(posedge clk) disable iff (rst)
        $countones(lamps[11:9]) == 1);
    a_r11_ped_one: assert property (@(posedge clk) disable iff (rst)
        $countones(lamps[15:13]) == 1);
    a_r11_h2_nror_dark: assert property (@(posedge clk) disable iff (rst)
        !lamps[8]);
    a_r2_nror_with_arrow: assert property (@(posedge clk) disable iff (rst)
        lamps[12] == (lamps[4] | lamps[3]));
    a_r2_cross_excludes_main: assert property (@(posedge clk) disable iff (rst)
        (lamps[7] | lamps[6]) |-> (lamps[0] && lamps[9]));
    a_r10_change_after_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(lamps));
    a_r5_request_holds: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !take) |=> walk_req);
    a_r5_take_enters_walk: assert property (@(posedge clk) disable iff (rst)
        take |=> (phase == PH_PED_GO));
    a_r7_arrow_extends: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ARROW_GO && car && short_done) |=> (phase == PH_ARROW_GO));
endmodule

bind tl_sequencer tl_sequencer_chk u_chk (
    .clk(clk), .rst(rst), .lamps(lamps_o), .tick(tick), .phase(phase_q),
    .walk_req(walk_req), .take(walk_take), .car(car_sense_i), .short_done(short_done)
);

// File: tb/sim_tl_sequencer.sv
module sim_tl_sequencer;
    localparam logic [15:0] L_MAIN_GO    = 16'h2824;
    localparam logic [15:0] L_MAIN_WARN  = 16'h2422;
    localparam logic [15:0] L_CROSS_GO   = 16'h2281;
    localparam logic [15:0] L_CROSS_WARN = 16'h2241;
    localparam logic [15:0] L_PED_GO     = 16'h8221;
    localparam logic [15:0] L_PED_CLEAR  = 16'h4221;
    localparam logic [15:0] L_ARROW_GO   = 16'h3231;
    localparam logic [15:0] L_ARROW_WARN = 16'h3229;

    logic clk = 0, rst = 1, slow = 0, walk = 0, car = 0, gen_en = 0;
    logic [15:0] lamps;
    int edges_seen = 0, slow_div = 0, checks = 0, fails = 0;

    always #5 clk = ~clk;

    tl_sequencer u0 (
        .clk(clk), .rst(rst), .slow_clk_i(slow), .walk_btn_i(walk),
        .car_sense_i(car), .lamps_o(lamps)
    );

    always @(posedge clk) begin
        if (gen_en) begin
            if (slow_div == 9) begin
                slow_div <= 0;
                slow <= ~slow;
                if (!slow) edges_seen <= edges_seen + 1;
            end else slow_div <= slow_div + 1;
        end
    end

    typedef struct {
        logic [15:0] lamps;
        int          dur;
        string       tag;
    } item_t;
    item_t q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] v, input int d, input string tag);
        q.push_back('{v, d, tag});
    endtask

    task automatic push_main_cross(input string tag);
        push(L_MAIN_WARN, 15, tag);
        push(L_CROSS_GO, 4, tag);
        push(L_CROSS_WARN, 15, tag);
    endtask

    task automatic wait_for(input logic [15:0] v);
        while (lamps !== v) @(negedge clk);
    endtask

    task automatic press_walk();
        @(negedge clk); walk = 1;
        repeat (3) @(negedge clk);
        walk = 0;
    endtask

    // monitor: scoreboard of phase changes with their lengths in slow edges
    logic [15:0] prev;
    int mark;
    always @(negedge clk) begin
        if (rst) begin
            prev = lamps;
            mark = edges_seen;
        end else if (lamps !== prev) begin
            if (q.size() == 0) check(0, "R10", "unexpected lamp change", lamps, prev);
            else begin
                item_t it;
                it = q.pop_front();
                check(lamps == it.lamps, it.tag, "phase lamps", lamps, it.lamps);
                check(edges_seen - mark == it.dur, it.tag, "previous phase length",
                      edges_seen - mark, it.dur);
            end
            prev = lamps;
            mark = edges_seen;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(lamps == L_MAIN_GO, "R1", "lamps after reset", lamps, L_MAIN_GO);
        check($countones(lamps[2:0]) == 1 && $countones(lamps[15:13]) == 1 && !lamps[8],
              "R11", "one lamp per head", lamps, L_MAIN_GO);
        gen_en = 1;

        // R3 plain cycle, R9 car seen only during green phases
        push_main_cross("R3");
        push(L_MAIN_GO, 4, "R9");
        car = 1;
        wait_for(L_CROSS_GO);
        car = 0;
        wait_for(L_MAIN_GO);

        // R4 walk inserted, R6 walk timing, R5 latch cleared afterwards
        press_walk();
        push_main_cross("R3");
        push(L_PED_GO, 4, "R4");
        push(L_PED_CLEAR, 15, "R6");
        push(L_MAIN_GO, 4, "R6");
        push_main_cross("R5");
        push(L_MAIN_GO, 4, "R5");
        wait_for(L_PED_GO);
        wait_for(L_MAIN_GO);
        wait_for(L_CROSS_GO);
        wait_for(L_MAIN_GO);

        // R7 arrow extended across one recheck, R8 arrow yellow
        car = 1;
        push_main_cross("R3");
        push(L_ARROW_GO, 4, "R4");
        push(L_ARROW_WARN, 8, "R7");
        push(L_MAIN_GO, 4, "R8");
        wait_for(L_ARROW_GO);
        begin
            int e0;
            e0 = edges_seen;
            while (edges_seen < e0 + 6) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        car = 0;
        wait_for(L_MAIN_GO);

        // R6 walk has priority, arrow follows clearing phase
        press_walk();
        car = 1;
        push_main_cross("R3");
        push(L_PED_GO, 4, "R4");
        push(L_PED_CLEAR, 15, "R6");
        push(L_ARROW_GO, 4, "R6");
        push(L_ARROW_WARN, 4, "R7");
        push(L_MAIN_GO, 4, "R8");
        wait_for(L_ARROW_GO);
        car = 0;
        wait_for(L_MAIN_GO);

        // R1 reset mid-phase with a pending request
        push(L_MAIN_WARN, 15, "R3");
        wait_for(L_MAIN_WARN);
        press_walk();
        @(negedge slow);
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(lamps == L_MAIN_GO, "R1", "lamps after mid-phase reset", lamps, L_MAIN_GO);
        push_main_cross("R1");
        push(L_MAIN_GO, 4, "R1");
        wait_for(L_CROSS_GO);
        wait_for(L_MAIN_GO);
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R10", "all expected phases seen", q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule